// File: doc/BRIEF.md
# Systolic Guard-Interval User Grouper

This block places users into pilot-sharing groups. A batch of spatial signature indices, already sorted in ascending order, is presented in parallel together with a user count and a one-cycle `start` pulse. A feeder state machine captures the batch and releases one index per clock into a chain of `TAU` compare stages. Each stage stands for one group and remembers the most recent index that group took. An index that is at least `GUARD` above that stored index, or that reaches a group that is still empty, is taken by that group. Any other index moves on to the next stage. An index that no stage takes leaves the chain marked as unassigned.

Every user leaves the tail of the chain as a record: its user number (its position in the input vector), its group number, an assigned flag and a last-of-batch flag. The chain holds `TAU` comparators and two registers per stage: the group reference and the travelling record. A batch of K users is finished K+`TAU` clock edges after the edge that samples `start`.

The feeder state machine has three states. `ST_IDLE` waits for an accepted start. `ST_FEED` issues one index per clock. `ST_DRAIN` waits for the last record to reach the tail. There are three transitions. start-accept (`ST_IDLE`→`ST_FEED`) fires when `start` is high and the count is nonzero. feed-end (`ST_FEED`→`ST_DRAIN`) fires when every user has been issued. drain-end (`ST_DRAIN`→`ST_IDLE`) fires when the tail shows a valid record with its last flag set.

Top module: `guard_user_grouper`

## Requirements
- R1: After reset, `busy` and `out_vld` are 0.
- R2: Users leave in input order. Each record's `out_uid` equals the user's position j in `idx_vec`, where user j occupies bits [j*IDX_W +: IDX_W]. User j's record is valid just after the (TAU+j)-th rising edge that follows the edge sampling `start`.
- R3: A group that has taken no index in the current batch accepts the first unassigned index that reaches it. The first user of a batch therefore always lands in group 0.
- R4: An occupied group accepts an index only when that index ≥ (the group's last accepted index + GUARD). A spacing of exactly GUARD is accepted, and a spacing of GUARD-1 is rejected.
- R5: An index joins the lowest-numbered group that can accept it. Once an index is assigned, later stages leave its record unchanged.
- R6: An index that no group accepts leaves with `out_ok`=0 and `out_grp`=0.
- R7: `out_last` is 1 only on the record of the final user. `busy` is 1 from the start edge through edge TAU+K-1 and is 0 after edge TAU+K, where K is the effective count.
- R8: A `start` is ignored while `busy` is 1. A `start` with `user_cnt`=0 is ignored. A `user_cnt` above NUSR is treated as NUSR.
- R9: Every group is emptied when a batch is accepted, so results do not depend on earlier batches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Batch request pulse |
| user_cnt | input | CNT_W (4) | Number of users in the batch |
| idx_vec | input | NUSR*IDX_W (56) | Sorted indices, user j at bits [j*IDX_W +: IDX_W] |
| busy | output | 1 | Batch in progress |
| out_vld | output | 1 | Record valid at the chain tail |
| out_uid | output | UID_W (3) | User number of the record |
| out_grp | output | GRP_W (2) | Group number (0 when unassigned) |
| out_ok | output | 1 | User was assigned to a group |
| out_last | output | 1 | Record belongs to the final user |

## Verification
The spacing boundary is the sharpest corner. A design with an off-by-one compare would either merge indices GUARD-1 apart or split indices exactly GUARD apart, and both directed ramps expose that. Equal indices must fill every group and then overflow as unassigned with group 0. A grouper that compared against the first index a group took, rather than the most recent one, would mis-place the alternating ramp. Back-to-back batches catch groups that are not emptied between batches. A start pulse issued mid-batch and a zero count must leave the output stream and the `busy` timing unchanged. Hundreds of pseudo-random sorted batches with gaps around GUARD, checked against an arithmetic greedy model, cover the remaining orderings.

// File: rtl/grp_pkg.sv
package grp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FEED  = 2'd1,
        ST_DRAIN = 2'd2
    } feed_state_t;
endpackage

// File: rtl/grp_feeder.sv
module grp_feeder
    import grp_pkg::*;
#(
    parameter int NUSR  = 8,
    parameter int IDX_W = 7,
    parameter int UID_W = 3,
    parameter int CNT_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [CNT_W-1:0]      user_cnt,
    input  logic [NUSR*IDX_W-1:0] idx_vec,
    input  logic                  chain_done,
    output logic                  busy,
    output logic                  clr,
    output logic                  s_vld,
    output logic [IDX_W-1:0]      s_idx,
    output logic [UID_W-1:0]      s_uid,
    output logic                  s_last
);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(NUSR);

    feed_state_t state_q, state_d;
    logic [IDX_W-1:0] vec_in [NUSR];
    logic [IDX_W-1:0] vec_q  [NUSR];
    logic [CNT_W-1:0] cnt_q, n_q, n_eff;
    logic             go;

    for (genvar j = 0; j < NUSR; j++) begin : g_unpack
        assign vec_in[j] = idx_vec[j*IDX_W +: IDX_W];
    end

    assign n_eff = (user_cnt > MAX_CNT) ? MAX_CNT : user_cnt;
    assign go    = (state_q == ST_IDLE) && start && (user_cnt != '0);
    assign clr   = go;
    assign busy  = (state_q != ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go)                state_d = ST_FEED;
            ST_FEED:  if (cnt_q >= n_q)      state_d = ST_DRAIN;
            ST_DRAIN: if (chain_done)        state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // outputs and batch storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_vld  <= 1'b0;
            s_idx  <= '0;
            s_uid  <= '0;
            s_last <= 1'b0;
            cnt_q  <= '0;
            n_q    <= '0;
            for (int j = 0; j < NUSR; j++) vec_q[j] <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        for (int j = 0; j < NUSR; j++) vec_q[j] <= vec_in[j];
                        n_q    <= n_eff;
                        cnt_q  <= CNT_W'(1);
                        s_vld  <= 1'b1;
                        s_idx  <= vec_in[0];
                        s_uid  <= '0;
                        s_last <= (n_eff == CNT_W'(1));
                    end else begin
                        s_vld  <= 1'b0;
                        s_last <= 1'b0;
                    end
                end
                ST_FEED: begin
                    if (cnt_q < n_q) begin
                        s_vld  <= 1'b1;
                        s_idx  <= vec_q[cnt_q[UID_W-1:0]];
                        s_uid  <= cnt_q[UID_W-1:0];
                        s_last <= ((cnt_q + CNT_W'(1)) == n_q);
                        cnt_q  <= cnt_q + CNT_W'(1);
                    end else begin
                        s_vld  <= 1'b0;
                        s_last <= 1'b0;
                    end
                end
                ST_DRAIN: begin
                    s_vld  <= 1'b0;
                    s_last <= 1'b0;
                end
                default: begin
                    s_vld  <= 1'b0;
                    s_last <= 1'b0;
                end
            endcase
        end
    end

    AST_UID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && $past(s_vld)) |-> (s_uid == $past(s_uid) + UID_W'(1))); // R2

    AST_NO_FEED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |=> !s_vld); // R7
endmodule

// File: rtl/grp_pe.sv
module grp_pe #(
    parameter int IDX_W = 7,
    parameter int UID_W = 3,
    parameter int GRP_W = 2,
    parameter int GUARD = 3,
    parameter int PE_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             in_vld,
    input  logic [IDX_W-1:0] in_idx,
    input  logic [UID_W-1:0] in_uid,
    input  logic             in_ok,
    input  logic [GRP_W-1:0] in_grp,
    input  logic             in_last,
    output logic             out_vld,
    output logic [IDX_W-1:0] out_idx,
    output logic [UID_W-1:0] out_uid,
    output logic             out_ok,
    output logic [GRP_W-1:0] out_grp,
    output logic             out_last
);
    localparam int CMP_W = IDX_W + 2;
    localparam logic [GRP_W-1:0] MY_GRP = GRP_W'(PE_ID);

    logic             occ_q;
    logic [IDX_W-1:0] ref_q;
    logic [CMP_W-1:0] thr;
    logic             fits, take;

    assign thr  = {2'b00, ref_q} + CMP_W'(GUARD);
    assign fits = !occ_q || ({2'b00, in_idx} >= thr);
    assign take = in_vld && !in_ok && fits;

    // group reference
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q <= 1'b0;
            ref_q <= '0;
        end else if (clr) begin
            occ_q <= 1'b0;
        end else if (take) begin
            occ_q <= 1'b1;
            ref_q <= in_idx;
        end
    end

    // travelling record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_idx  <= '0;
            out_uid  <= '0;
            out_ok   <= 1'b0;
            out_grp  <= '0;
            out_last <= 1'b0;
        end else begin
            out_vld  <= in_vld;
            out_idx  <= in_idx;
            out_uid  <= in_uid;
            out_ok   <= in_ok || take;
            out_grp  <= take ? MY_GRP : in_grp;
            out_last <= in_last;
        end
    end

    AST_REF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_ok && out_grp == MY_GRP) |-> (occ_q && ref_q == out_idx)); // R4

    AST_KEEP_ASSIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_ok) |=> (out_ok && out_grp == $past(in_grp))); // R5
endmodule

// File: rtl/guard_user_grouper.sv
module guard_user_grouper #(
    parameter int NUSR  = 8,
    parameter int IDX_W = 7,
    parameter int TAU   = 4,
    parameter int GUARD = 3,
    parameter int UID_W = $clog2(NUSR),
    parameter int GRP_W = $clog2(TAU),
    parameter int CNT_W = $clog2(NUSR + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [CNT_W-1:0]      user_cnt,
    input  logic [NUSR*IDX_W-1:0] idx_vec,
    output logic                  busy,
    output logic                  out_vld,
    output logic [UID_W-1:0]      out_uid,
    output logic [GRP_W-1:0]      out_grp,
    output logic                  out_ok,
    output logic                  out_last
);
    logic             c_vld  [TAU+1];
    logic [IDX_W-1:0] c_idx  [TAU+1];
    logic [UID_W-1:0] c_uid  [TAU+1];
    logic             c_ok   [TAU+1];
    logic [GRP_W-1:0] c_grp  [TAU+1];
    logic             c_last [TAU+1];
    logic             clr, chain_done;

    assign chain_done = c_vld[TAU] && c_last[TAU];

    grp_feeder #(
        .NUSR(NUSR), .IDX_W(IDX_W), .UID_W(UID_W), .CNT_W(CNT_W)
    ) u_feed (
        .clk(clk), .rst_n(rst_n), .start(start), .user_cnt(user_cnt),
        .idx_vec(idx_vec), .chain_done(chain_done), .busy(busy), .clr(clr),
        .s_vld(c_vld[0]), .s_idx(c_idx[0]), .s_uid(c_uid[0]), .s_last(c_last[0])
    );

    assign c_ok[0]  = 1'b0;
    assign c_grp[0] = '0;

    for (genvar g = 0; g < TAU; g++) begin : g_chain
        grp_pe #(
            .IDX_W(IDX_W), .UID_W(UID_W), .GRP_W(GRP_W),
            .GUARD(GUARD), .PE_ID(g)
        ) u_pe (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .in_vld(c_vld[g]), .in_idx(c_idx[g]), .in_uid(c_uid[g]),
            .in_ok(c_ok[g]), .in_grp(c_grp[g]), .in_last(c_last[g]),
            .out_vld(c_vld[g+1]), .out_idx(c_idx[g+1]), .out_uid(c_uid[g+1]),
            .out_ok(c_ok[g+1]), .out_grp(c_grp[g+1]), .out_last(c_last[g+1])
        );
    end

    assign out_vld  = c_vld[TAU];
    assign out_uid  = c_uid[TAU];
    assign out_grp  = c_grp[TAU];
    assign out_ok   = c_ok[TAU];
    assign out_last = c_last[TAU];

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_vld); // R7

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_last) |=> !busy); // R7

    AST_UNASSIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_ok) |-> (out_grp == '0)); // R6

    AST_FIRST_GROUP0: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_uid == '0) |-> (out_ok && out_grp == '0)); // R3
endmodule

// File: tb/test_guard_user_grouper.sv
module test_guard_user_grouper;
    localparam int NUSR  = 8;
    localparam int IDX_W = 7;
    localparam int TAU   = 4;
    localparam int GUARD = 3;
    localparam int UID_W = 3;
    localparam int GRP_W = 2;
    localparam int CNT_W = 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  start = 1'b0;
    logic [CNT_W-1:0]      user_cnt = '0;
    logic [NUSR*IDX_W-1:0] idx_vec = '0;
    logic                  busy, out_vld, out_ok, out_last;
    logic [UID_W-1:0]      out_uid;
    logic [GRP_W-1:0]      out_grp;

    int checks = 0;
    int failures = 0;
    bit reported = 0;
    int b_idx [NUSR];
    int e_grp [NUSR];
    bit e_ok  [NUSR];
    int seed = 12345;

    always #4 clk = ~clk;

    guard_user_grouper #(.NUSR(NUSR), .IDX_W(IDX_W), .TAU(TAU), .GUARD(GUARD)) i_guard_user_grouper (
        .clk(clk), .rst_n(rst_n), .start(start), .user_cnt(user_cnt), .idx_vec(idx_vec),
        .busy(busy), .out_vld(out_vld), .out_uid(out_uid), .out_grp(out_grp),
        .out_ok(out_ok), .out_last(out_last)
    );

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
    endtask

    function automatic int rnd(input int m);
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        return (seed >>> 8) % m;
    endfunction

    // greedy reference: groups cleared per batch (R9)
    task automatic model(input int cnt);
        int last [TAU];
        bit occ  [TAU];
        for (int g = 0; g < TAU; g++) begin occ[g] = 0; last[g] = 0; end
        for (int j = 0; j < cnt; j++) begin
            e_ok[j] = 0; e_grp[j] = 0;
            for (int g = 0; g < TAU; g++) begin
                if (!e_ok[j] && (!occ[g] || b_idx[j] >= last[g] + GUARD)) begin
                    e_ok[j] = 1; e_grp[j] = g; occ[g] = 1; last[g] = b_idx[j];
                end
            end
        end
    endtask

    task automatic run_batch(input int cnt_in, input bit probe);
        int cnt, seen;
        cnt = (cnt_in > NUSR) ? NUSR : cnt_in;
        model(cnt);
        @(negedge clk);
        user_cnt = CNT_W'(cnt_in);
        for (int j = 0; j < NUSR; j++) idx_vec[j*IDX_W +: IDX_W] = IDX_W'(b_idx[j]);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        seen = 0;
        for (int n = 0; n <= TAU + cnt + 1; n++) begin
            if (out_vld) begin
                chk(n == TAU + seen, "R2 timing", n, TAU + seen);
                chk(int'(out_uid) == seen, "R2 uid", out_uid, seen);
                chk(out_ok == e_ok[seen], "R4 ok", out_ok, e_ok[seen]);
                if (e_ok[seen]) chk(int'(out_grp) == e_grp[seen], "R5 grp", out_grp, e_grp[seen]);
                else            chk(out_grp == '0, "R6 grp", out_grp, 0);
                chk(out_last == (seen == cnt - 1), "R7 last", out_last, seen == cnt - 1);
                seen++;
            end
            if (n == TAU + cnt - 1) chk(busy == 1'b1, "R7 busy high", busy, 1);
            if (n == TAU + cnt)     chk(busy == 1'b0, "R7 busy low", busy, 0);
            if (probe && n == 1) begin
                start = 1'b1; user_cnt = CNT_W'(NUSR); idx_vec = '0;
            end
            if (probe && n == 3) start = 1'b0;
            @(posedge clk);
            @(negedge clk);
        end
        chk(seen == cnt, "R2 count", seen, cnt);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(out_vld == 1'b0, "R1 out_vld", out_vld, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && out_vld == 1'b0, "R1 after release", busy, 0);

        // spacing exactly GUARD: all in group 0 (R4, R3)
        for (int j = 0; j < NUSR; j++) b_idx[j] = j * GUARD;
        run_batch(NUSR, 0);
        // spacing GUARD-1: alternating groups (R4, R5)
        for (int j = 0; j < NUSR; j++) b_idx[j] = j * (GUARD - 1);
        run_batch(NUSR, 0);
        // equal indices: groups fill then overflow (R6)
        for (int j = 0; j < NUSR; j++) b_idx[j] = 5;
        run_batch(NUSR, 0);
        // same again right after: groups emptied (R9)
        run_batch(NUSR, 0);
        // start during busy ignored (R8)
        for (int j = 0; j < NUSR; j++) b_idx[j] = 10 + j;
        run_batch(6, 1);
        // oversized count clamps (R8)
        run_batch(12, 0);
        // zero count ignored (R8)
        @(negedge clk);
        user_cnt = '0; start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < TAU + 3; n++) begin
            chk(busy == 1'b0 && out_vld == 1'b0, "R8 zero count", busy, 0);
            @(posedge clk); @(negedge clk);
        end
        // single user (R3, R7)
        b_idx[0] = 127;
        run_batch(1, 0);

        // pseudo-random sorted batches
        for (int t = 0; t < 400; t++) begin
            int cnt, v;
            cnt = 1 + rnd(NUSR);
            v = rnd(12);
            for (int j = 0; j < NUSR; j++) begin
                b_idx[j] = (v > 127) ? 127 : v;
                v = v + rnd(6);
            end
            run_batch(cnt, (t % 37) == 0);
        end

        report();
        $finish;
    end
endmodule